// File: doc/BRIEF.md
# Programmable External Parallel Bus Controller

This block is the master side of an external parallel bus used to reach asynchronous or slow synchronous peripherals such as NOR flash, FPGA register files or UART-style devices. It accepts one read or write at a time from an internal valid/ready request port. It runs the access on the external pins as a fixed sequence of phases:

- chip-enable setup
- address (with an optional multiplexed address/data window)
- strobe
- wait for ready
- an optional extra capture cycle
- chip-enable hold

It then returns a one-cycle completion pulse carrying the read data.

Every phase length comes from a timing input that counts in programmed value plus one cycles. The short fields (setup, address-valid, multiplexed window, write strobe, hold) are 4 bits wide. The output-strobe and wait fields are 8 bits wide. Each of the ready, address-valid, strobe and chip-enable pins has its own polarity control. The data bus runs 16 or 32 bits wide. Ready may be set to lead read data by one cycle or to coincide with it. The block does no address decoding. It drives a single chip-enable and a 28-bit address that covers a 256 MB window.

Top module: `pbus_master`

## Requirements
- R1: After a request is accepted, chip-enable stays inactive for exactly tm_setup+1 cycles (the setup phase).
- R2: Chip-enable then asserts, and address-valid is active for the first tm_adv+1 cycles of the address phase. With cfg_mux=1 the zero-extended address is driven on the enabled data lanes for the first tm_mux+1 cycles, and the phase lasts max(tm_mux,tm_adv)+1 cycles. With cfg_mux=0 the phase lasts tm_adv+1 cycles.
- R3: The strobe phase lasts the strobe width plus one cycle: tm_oe for reads, tm_we for writes. The output strobe (reads) or the write strobe (writes) stays active through the strobe, wait and capture phases. The two strobes are never active together.
- R4: In the wait phase, ready is ignored during the first tm_wait cycles. From wait cycle tm_wait onward the access stays in the wait phase until ready is seen active.
- R5: With cfg_rdy_early=0, read data is captured in the cycle where ready is first accepted. With cfg_rdy_early=1, one extra capture cycle with the strobe still active follows, and the data is captured there.
- R6: After the strobe deasserts, chip-enable stays active for tm_hold+1 cycles. rsp_done then pulses high for exactly one cycle, in the first cycle back in idle, with rsp_rdata valid.
- R7: Each polarity bit (cfg_cs_hi, cfg_adv_hi, cfg_strb_hi, cfg_rdy_hi) set to 1 makes its pin active high; set to 0, the pin is active low. The strobe bit applies to both bus_oe and bus_we.
- R8: cfg_wide=1 selects 32 bits, which is two 16-bit lanes. cfg_wide=0 selects 16 bits: only lane 0 (bits 15:0) is driven, the upper 16 bits of rsp_rdata read as zero, and bus_be_n[3:2] stays high. bus_be_n is active low (bit k covers byte k) and is active only while chip-enable is active.
- R9: bus_d_oe (bit k enables data bits 16k+15:16k) is set only during multiplexed address cycles and, on writes, from the strobe phase through the end of hold, when bus_d_out carries the write data.
- R10: req_ready is high exactly when idle, including during reset. Only one transfer is outstanding. A request held valid while busy is not taken until the current access has finished.
- R11: bus_addr carries the accepted request address for the whole time chip-enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 28 | Byte address inside the 256 MB window |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, active high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| cfg_wide | input | 1 | 1 selects a 32-bit bus, 0 selects 16 bits |
| cfg_mux | input | 1 | Multiplexed address/data mode |
| cfg_rdy_early | input | 1 | Ready leads read data by one cycle |
| cfg_rdy_hi | input | 1 | Ready pin is active high |
| cfg_adv_hi | input | 1 | Address-valid pin is active high |
| cfg_strb_hi | input | 1 | Output and write strobe pins are active high |
| cfg_cs_hi | input | 1 | Chip-enable pin is active high |
| tm_mux | input | 4 | Multiplexed address window, value+1 cycles |
| tm_hold | input | 4 | Chip-enable hold, value+1 cycles |
| tm_adv | input | 4 | Address-valid width, value+1 cycles |
| tm_setup | input | 4 | Chip-enable setup, value+1 cycles |
| tm_we | input | 4 | Write strobe width, value+1 cycles |
| tm_oe | input | 8 | Output strobe width, value+1 cycles |
| tm_wait | input | 8 | Wait cycles before ready is sampled |
| bus_cs | output | 1 | Chip-enable pin |
| bus_adv | output | 1 | Address-valid pin |
| bus_oe | output | 1 | Output-enable strobe pin |
| bus_we | output | 1 | Write-enable strobe pin |
| bus_addr | output | 28 | Address pins |
| bus_be_n | output | 4 | Byte-enable pins, active low |
| bus_d_out | output | 32 | Data lines, driven value |
| bus_d_oe | output | 2 | Data output enable per 16-bit lane |
| bus_d_in | input | 32 | Data lines, sampled value |
| bus_rdy | input | 1 | Ready pin from the device |

## Verification
Every pin is a decode of registered state, so the effect of an accepted request appears in the first cycle after the accepting edge. The expected pins for cycle i are worked out from the running sum of phase lengths: setup tm_setup+1, then the address phase, then strobe width+1, then max(tm_wait, ready delay)+1, then one capture cycle in early mode, then tm_hold+1. The done pulse and read data are due exactly in the cycle after the last hold cycle. The bench samples every output at the falling edge of each such cycle and changes ready and the data lines at that same point. Data lines carry the correct word only in the one cycle that R5 names, so a capture one cycle early or late returns the wrong word.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ADDR  = 3'd2,
    ST_STRB  = 3'd3,
    ST_WAIT  = 3'd4,
    ST_CAPT  = 3'd5,
    ST_HOLD  = 3'd6
  } pbus_state_e;

  // Power-on timing values a register front end is expected to load.
  localparam int unsigned TM_MUX_DFLT   = 1;
  localparam int unsigned TM_HOLD_DFLT  = 1;
  localparam int unsigned TM_ADV_DFLT   = 1;
  localparam int unsigned TM_SETUP_DFLT = 4;
  localparam int unsigned TM_WE_DFLT    = 1;
  localparam int unsigned TM_OE_DFLT    = 1;
  localparam int unsigned TM_WAIT_DFLT  = 3;

endpackage

// File: rtl/pbus_phase_cnt.sv
module pbus_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;

  // Saturating count of cycles spent in the current phase.
  always_comb begin
    if (clr)
      cnt_d = '0;
    else if (cnt != {CNT_W{1'b1}})
      cnt_d = cnt + 1'b1;
    else
      cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= cnt_d;
  end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               is_write,
  input  logic               cfg_mux,
  input  logic               cfg_rdy_early,
  input  logic               rdy_act,
  input  logic [SHORT_W-1:0] tm_mux,
  input  logic [SHORT_W-1:0] tm_hold,
  input  logic [SHORT_W-1:0] tm_adv,
  input  logic [SHORT_W-1:0] tm_setup,
  input  logic [SHORT_W-1:0] tm_we,
  input  logic [LONG_W-1:0]  tm_oe,
  input  logic [LONG_W-1:0]  tm_wait,
  output logic               idle,
  output logic               cs_act,
  output logic               adv_act,
  output logic               oe_act,
  output logic               we_act,
  output logic               addr_drv,
  output logic               data_drv,
  output logic               capture,
  output logic               done
);

  localparam int PAD_W = LONG_W - SHORT_W;

  pbus_state_e       st_q, st_d;
  logic [LONG_W-1:0] cnt;
  logic              clr;
  logic              done_d;
  logic              wait_go;
  logic              strb_on;
  logic [LONG_W-1:0] mux_x, hold_x, adv_x, setup_x, we_x;
  logic [LONG_W-1:0] addr_last, strb_last;

  assign mux_x   = {{PAD_W{1'b0}}, tm_mux};
  assign hold_x  = {{PAD_W{1'b0}}, tm_hold};
  assign adv_x   = {{PAD_W{1'b0}}, tm_adv};
  assign setup_x = {{PAD_W{1'b0}}, tm_setup};
  assign we_x    = {{PAD_W{1'b0}}, tm_we};

  // Last count of the address phase: the wider of the two windows when
  // multiplexed, the address-valid window otherwise.
  assign addr_last = (cfg_mux && (mux_x > adv_x)) ? mux_x : adv_x;
  assign strb_last = is_write ? we_x : tm_oe;

  assign wait_go = (st_q == ST_WAIT) && (cnt >= tm_wait) && rdy_act;

  pbus_phase_cnt #(.CNT_W(LONG_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .cnt   (cnt)
  );

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_SETUP;
      ST_SETUP: if (cnt == setup_x) st_d = ST_ADDR;
      ST_ADDR:  if (cnt == addr_last) st_d = ST_STRB;
      ST_STRB:  if (cnt == strb_last) st_d = ST_WAIT;
      ST_WAIT:  if (wait_go) st_d = cfg_rdy_early ? ST_CAPT : ST_HOLD;
      ST_CAPT:  st_d = ST_HOLD;
      ST_HOLD: begin
        if (cnt == hold_x) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  assign clr = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  // Output decode from registered state.
  assign strb_on  = (st_q == ST_STRB) || (st_q == ST_WAIT) || (st_q == ST_CAPT);
  assign idle     = (st_q == ST_IDLE);
  assign cs_act   = !idle && (st_q != ST_SETUP);
  assign adv_act  = (st_q == ST_ADDR) && (cnt <= adv_x);
  assign addr_drv = (st_q == ST_ADDR) && cfg_mux && (cnt <= mux_x);
  assign oe_act   = strb_on && !is_write;
  assign we_act   = strb_on && is_write;
  assign data_drv = is_write && (strb_on || (st_q == ST_HOLD));
  assign capture  = (wait_go && !cfg_rdy_early) || (st_q == ST_CAPT);

  p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_act && we_act));

  p_setup_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP && cnt < setup_x) |=> (st_q == ST_SETUP));

  p_wait_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && cnt < tm_wait) |=> (st_q == ST_WAIT));

  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && cnt < hold_x) |=> (st_q == ST_HOLD && cs_act));

  p_capt_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT) |=> (st_q == ST_HOLD));

endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int LANE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/8-1:0]        req_be,
  input  logic                       cfg_wide,
  input  logic                       capture,
  input  logic                       addr_drv,
  input  logic                       data_drv,
  input  logic                       cs_act,
  input  logic [DATA_W-1:0]          bus_d_in,
  output logic                       lat_write,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic [DATA_W/8-1:0]        bus_be_n,
  output logic [DATA_W-1:0]          bus_d_out,
  output logic [DATA_W/LANE_W-1:0]   bus_d_oe,
  output logic [DATA_W-1:0]          rsp_rdata
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int BE_W  = DATA_W / 8;
  localparam int BPL   = LANE_W / 8;
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic [DATA_W-1:0] addr_ext;
  logic [LANES-1:0]  lane_en;

  assign addr_ext = {{PAD_W{1'b0}}, addr_q};

  // Request capture, with an explicit load enable.
  always_comb begin
    addr_d = addr_q;
    wdat_d = wdat_q;
    be_d   = be_q;
    wr_d   = wr_q;
    if (accept) begin
      addr_d = req_addr;
      wdat_d = req_wdata;
      be_d   = req_be;
      wr_d   = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      be_q   <= '0;
      wr_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      be_q   <= be_d;
      wr_q   <= wr_d;
      rdat_q <= rdat_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LANE_W;
    localparam int BO = l * BPL;

    if (l == 0) begin : g_base
      assign lane_en[l] = 1'b1;
    end else begin : g_upper
      assign lane_en[l] = cfg_wide;
    end

    assign bus_d_out[LO +: LANE_W] = addr_drv ? addr_ext[LO +: LANE_W]
                                              : wdat_q[LO +: LANE_W];
    assign bus_d_oe[l]             = lane_en[l] && (addr_drv || data_drv);
    assign bus_be_n[BO +: BPL]     = ~(be_q[BO +: BPL] & {BPL{lane_en[l] && cs_act}});

    always_comb begin
      if (capture)
        rdat_d[LO +: LANE_W] = lane_en[l] ? bus_d_in[LO +: LANE_W] : '0;
      else
        rdat_d[LO +: LANE_W] = rdat_q[LO +: LANE_W];
    end
  end

  assign lat_write = wr_q;
  assign bus_addr  = addr_q;
  assign rsp_rdata = rdat_q;

  p_dout_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_d_oe != '0) |-> cs_act);

  p_narrow_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wide |-> (bus_d_oe[LANES-1:1] == '0));

endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 16,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_be,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic                     cfg_wide,
  input  logic                     cfg_mux,
  input  logic                     cfg_rdy_early,
  input  logic                     cfg_rdy_hi,
  input  logic                     cfg_adv_hi,
  input  logic                     cfg_strb_hi,
  input  logic                     cfg_cs_hi,
  input  logic [SHORT_W-1:0]       tm_mux,
  input  logic [SHORT_W-1:0]       tm_hold,
  input  logic [SHORT_W-1:0]       tm_adv,
  input  logic [SHORT_W-1:0]       tm_setup,
  input  logic [SHORT_W-1:0]       tm_we,
  input  logic [LONG_W-1:0]        tm_oe,
  input  logic [LONG_W-1:0]        tm_wait,
  output logic                     bus_cs,
  output logic                     bus_adv,
  output logic                     bus_oe,
  output logic                     bus_we,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [DATA_W/8-1:0]      bus_be_n,
  output logic [DATA_W-1:0]        bus_d_out,
  output logic [DATA_W/LANE_W-1:0] bus_d_oe,
  input  logic [DATA_W-1:0]        bus_d_in,
  input  logic                     bus_rdy
);

  logic idle, cs_act, adv_act, oe_act, we_act;
  logic addr_drv, data_drv, capture, lat_write;
  logic accept, rdy_act;

  assign req_ready = idle;
  assign accept    = req_valid && idle;
  assign rdy_act   = cfg_rdy_hi ? bus_rdy : !bus_rdy;

  pbus_seq #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .is_write      (lat_write),
    .cfg_mux       (cfg_mux),
    .cfg_rdy_early (cfg_rdy_early),
    .rdy_act       (rdy_act),
    .tm_mux        (tm_mux),
    .tm_hold       (tm_hold),
    .tm_adv        (tm_adv),
    .tm_setup      (tm_setup),
    .tm_we         (tm_we),
    .tm_oe         (tm_oe),
    .tm_wait       (tm_wait),
    .idle          (idle),
    .cs_act        (cs_act),
    .adv_act       (adv_act),
    .oe_act        (oe_act),
    .we_act        (we_act),
    .addr_drv      (addr_drv),
    .data_drv      (data_drv),
    .capture       (capture),
    .done          (rsp_done)
  );

  pbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .cfg_wide  (cfg_wide),
    .capture   (capture),
    .addr_drv  (addr_drv),
    .data_drv  (data_drv),
    .cs_act    (cs_act),
    .bus_d_in  (bus_d_in),
    .lat_write (lat_write),
    .bus_addr  (bus_addr),
    .bus_be_n  (bus_be_n),
    .bus_d_out (bus_d_out),
    .bus_d_oe  (bus_d_oe),
    .rsp_rdata (rsp_rdata)
  );

  // Pin polarity: a set bit makes the pin active high.
  assign bus_cs  = cfg_cs_hi   ? cs_act  : !cs_act;
  assign bus_adv = cfg_adv_hi  ? adv_act : !adv_act;
  assign bus_oe  = cfg_strb_hi ? oe_act  : !oe_act;
  assign bus_we  = cfg_strb_hi ? we_act  : !we_act;

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cs_act && bus_d_oe == '0));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  p_adv_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_act |-> cs_act);

endmodule

// File: tb/pbus_master_test.sv
module pbus_master_test;
  import pbus_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [27:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        cfg_wide, cfg_mux, cfg_rdy_early;
  logic        cfg_rdy_hi, cfg_adv_hi, cfg_strb_hi, cfg_cs_hi;
  logic [3:0]  tm_mux, tm_hold, tm_adv, tm_setup, tm_we;
  logic [7:0]  tm_oe, tm_wait;
  logic        bus_cs, bus_adv, bus_oe, bus_we;
  logic [27:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic [31:0] bus_d_out;
  logic [1:0]  bus_d_oe;
  logic [31:0] bus_d_in;
  logic        bus_rdy;

  int n_vec = 0;
  int n_bad = 0;
  int g_ts, g_ta, g_tm, g_tw, g_twe, g_toe, g_th;

  always #2 clk = !clk;

  pbus_master uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_wide(cfg_wide), .cfg_mux(cfg_mux), .cfg_rdy_early(cfg_rdy_early),
    .cfg_rdy_hi(cfg_rdy_hi), .cfg_adv_hi(cfg_adv_hi),
    .cfg_strb_hi(cfg_strb_hi), .cfg_cs_hi(cfg_cs_hi),
    .tm_mux(tm_mux), .tm_hold(tm_hold), .tm_adv(tm_adv), .tm_setup(tm_setup),
    .tm_we(tm_we), .tm_oe(tm_oe), .tm_wait(tm_wait),
    .bus_cs(bus_cs), .bus_adv(bus_adv), .bus_oe(bus_oe), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in), .bus_rdy(bus_rdy)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic pin(input logic act, input logic hi);
    return hi ? act : !act;
  endfunction

  task automatic chk(input bit ok, input string rq,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_tm(input int ts, input int ta, input int tm, input int tw,
                        input int twe, input int toe, input int th);
    g_ts = ts; g_ta = ta; g_tm = tm; g_tw = tw; g_twe = twe; g_toe = toe; g_th = th;
    tm_setup = 4'(ts); tm_adv = 4'(ta); tm_mux = 4'(tm); tm_wait = 8'(tw);
    tm_we = 4'(twe); tm_oe = 8'(toe); tm_hold = 4'(th);
  endtask

  task automatic set_pol(input int p);
    cfg_cs_hi   = p[0];
    cfg_strb_hi = p[1];
    cfg_adv_hi  = p[2];
    cfg_rdy_hi  = p[3];
    bus_rdy     = !cfg_rdy_hi;
  endtask

  // R7: idle pins sit at their inactive level for the selected polarity.
  task automatic chk_idle_pins();
    logic [3:0] a, e;
    @(negedge clk);
    a = {bus_cs, bus_adv, bus_oe, bus_we};
    e = {!cfg_cs_hi, !cfg_adv_hi, !cfg_strb_hi, !cfg_strb_hi};
    chk(a === e, "R7 idle pin levels", 64'(a), 64'(e));
  endtask

  // One transfer; every cycle is compared with a waveform built from the
  // phase lengths. Ready goes active r_at cycles into the wait phase.
  task automatic xfer(input bit wr, input logic [27:0] ad, input logic [31:0] dat,
                      input logic [3:0] be, input int r_at, input bit keep_valid);
    int la, ls, sp, a0, st0, w0, c0, h0, tot, cap, j;
    bit bad, e_cs, e_adv, e_oe, e_we, e_da, e_dd, strb;
    string tag;
    logic [63:0] fa, fe;
    logic [1:0]  lm, e_doe;
    logic [3:0]  bm, e_be;
    logic [31:0] mask, ea, e_do, e_rd;
    logic [5:0]  a_ct, e_ct;
    lm   = cfg_wide ? 2'b11 : 2'b01;
    bm   = cfg_wide ? 4'hF : 4'h3;
    mask = cfg_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    ea   = {4'b0, ad};
    la   = cfg_mux ? imax(g_tm, g_ta) + 1 : g_ta + 1;
    ls   = (wr ? g_twe : g_toe) + 1;
    sp   = imax(g_tw, r_at);
    a0   = g_ts + 1;
    st0  = a0 + la;
    w0   = st0 + ls;
    c0   = w0 + sp + 1;
    h0   = c0 + (cfg_rdy_early ? 1 : 0);
    tot  = h0 + g_th + 1;
    cap  = cfg_rdy_early ? w0 + sp + 1 : w0 + sp;
    bad  = 1'b0;
    tag  = "";
    fa   = '0;
    fe   = '0;

    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = dat; req_be = be;
    bus_d_in = ~dat;
    @(posedge clk);
    for (int i = 0; i <= tot; i++) begin
      @(negedge clk);
      req_valid = keep_valid && (i < tot);
      if (keep_valid) begin
        req_addr = ~ad; req_wdata = ~dat; req_write = !wr;
      end
      if (i < tot) begin
        e_cs  = (i >= a0);
        j     = i - a0;
        e_adv = e_cs && (i < st0) && (j <= g_ta);
        strb  = (i >= st0) && (i < h0);
        e_oe  = strb && !wr;
        e_we  = strb && wr;
        e_da  = e_cs && (i < st0) && cfg_mux && (j <= g_tm);
        e_dd  = wr && (i >= st0);
        e_doe = (e_da || e_dd) ? lm : 2'b00;
        e_do  = e_da ? ea : dat;
        e_be  = e_cs ? ~(be & bm) : 4'hF;
        a_ct  = {bus_cs, bus_adv, bus_oe, bus_we, req_ready, rsp_done};
        e_ct  = {pin(e_cs, cfg_cs_hi), pin(e_adv, cfg_adv_hi),
                 pin(e_oe, cfg_strb_hi), pin(e_we, cfg_strb_hi), 1'b0, 1'b0};
        if (!bad) begin
          if (bus_d_oe !== e_doe ||
              ((e_da || e_dd) && ((bus_d_out & mask) !== (e_do & mask)))) begin
            bad = 1'b1; tag = "R9 data drive";
            fa = {30'b0, bus_d_oe, bus_d_out & mask}; fe = {30'b0, e_doe, e_do & mask};
          end else if (bus_be_n !== e_be) begin
            bad = 1'b1; tag = "R8 byte enables";
            fa = 64'(bus_be_n); fe = 64'(e_be);
          end else if (e_cs && bus_addr !== ad) begin
            bad = 1'b1; tag = "R11 address pins";
            fa = 64'(bus_addr); fe = 64'(ad);
          end else if (a_ct !== e_ct) begin
            bad = 1'b1;
            fa = {26'b0, a_ct, 32'(i)}; fe = {26'b0, e_ct, 32'(i)};
            if (i < a0)       tag = "R1 setup phase";
            else if (i < st0) tag = "R2 address phase";
            else if (i < w0)  tag = "R3 strobe phase";
            else if (i < c0)  tag = "R4 wait phase";
            else if (i < h0)  tag = "R5 capture cycle";
            else              tag = "R6 hold phase";
          end
        end
      end else begin
        chk(!bad, tag, fa, fe);
        chk(rsp_done === 1'b1 && req_ready === 1'b1 && bus_cs === !cfg_cs_hi,
            "R6 done pulse after hold", {61'b0, rsp_done, req_ready, bus_cs},
            {61'b0, 1'b1, 1'b1, !cfg_cs_hi});
        if (!wr) begin
          e_rd = dat & mask;
          chk(rsp_rdata === e_rd, cfg_wide ? "R5 read capture" : "R8 narrow read",
              64'(rsp_rdata), 64'(e_rd));
        end
      end
      bus_rdy  = pin((i >= w0 + r_at) && (i < tot), cfg_rdy_hi);
      bus_d_in = (i == cap) ? dat : ~dat;
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int k;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    cfg_wide = 1'b1; cfg_mux = 1'b0; cfg_rdy_early = 1'b0;
    set_pol(0);
    set_tm(TM_SETUP_DFLT, TM_ADV_DFLT, TM_MUX_DFLT, TM_WAIT_DFLT,
           TM_WE_DFLT, TM_OE_DFLT, TM_HOLD_DFLT);
    bus_d_in = '0;
    repeat (3) @(negedge clk);
    // R10: reset state.
    chk(req_ready === 1'b1 && rsp_done === 1'b0 && bus_cs === 1'b1 && bus_d_oe === 2'b00,
        "R10 reset state", {60'b0, req_ready, rsp_done, bus_cs, |bus_d_oe},
        {60'b0, 4'b1010});
    @(negedge clk);
    rst_n = 1'b1;

    // Power-on timing values, both directions.
    xfer(1'b0, 28'h0ABC_DEF, 32'h1234_5678, 4'hF, 1, 1'b0);
    xfer(1'b1, 28'h0000_040, 32'hCAFE_F00D, 4'h5, 0, 1'b0);

    // Sweep A: every polarity and mode combination.
    k = 0;
    for (int p = 0; p < 16; p++) begin
      set_pol(p);
      chk_idle_pins();
      for (int m = 0; m < 16; m++) begin
        cfg_mux = m[0]; cfg_wide = m[1]; cfg_rdy_early = m[2];
        set_tm(k % 3, (k / 3) % 3, (k / 2) % 4, k % 2, (k / 5) % 3, (k / 7) % 3, k % 3);
        xfer(m[3], 28'(32'h0123_457 + k * 32'h1_1111), 32'hA5C3_0000 + 32'(k * 77),
             4'(k % 16), k % 3, 1'b0);
        k++;
      end
    end

    // Sweep B: timing fields against ready delay, multiplexed 32-bit bus.
    set_pol(0);
    cfg_mux = 1'b1; cfg_wide = 1'b1;
    k = 0;
    for (int ts = 0; ts < 3; ts++)
      for (int ta = 0; ta < 3; ta++)
        for (int tm = 0; tm < 3; tm++)
          for (int tw = 0; tw < 3; tw++)
            for (int r = 0; r < 4; r++)
              for (int wr = 0; wr < 2; wr++) begin
                cfg_rdy_early = k[0];
                set_tm(ts, ta, tm, tw, (ta + tm) % 3, (ts + tw) % 4, (tm + r) % 3);
                xfer(wr[0], 28'(32'h0F0_0F0 + k * 32'h33), 32'h5A5A_0000 ^ 32'(k * 1031),
                     4'(15 - k % 16), r, 1'b0);
                k++;
              end

    // R10: a request held valid while busy is not taken early.
    set_pol(5);
    cfg_mux = 1'b0; cfg_wide = 1'b0; cfg_rdy_early = 1'b1;
    set_tm(1, 2, 0, 1, 2, 3, 1);
    xfer(1'b0, 28'h0BEE_F00, 32'h8765_4321, 4'hF, 2, 1'b1);
    xfer(1'b1, 28'h0000_002, 32'h0000_BEEF, 4'hC, 0, 1'b0);

    // Long fields at their upper limits.
    set_pol(10);
    cfg_wide = 1'b1; cfg_mux = 1'b1; cfg_rdy_early = 1'b0;
    set_tm(15, 15, 15, 200, 15, 255, 15);
    xfer(1'b0, 28'h0FF_FFFF, 32'hDEAD_BEEF, 4'hF, 230, 1'b0);
    set_tm(15, 0, 15, 255, 15, 255, 15);
    xfer(1'b1, 28'h0800_000, 32'h0F1E_2D3C, 4'h9, 5, 1'b0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule